// File: doc/BRIEF.md
# Serial Flash Master Shift Engine

This block is the master side of a single-lane serial flash link. Software-facing logic outside the block pushes 32-bit words into a transmit queue. Each push names a write port, and the port gives the word a byte count of four, one, two or three. The engine takes words from the queue one at a time. It sends the low byte first, and each byte goes out most significant bit first. For every byte it sends, it captures one byte from the slave. When a word is done, it puts a receive entry holding those bytes and their count into a receive queue.

The serial clock rate, the clock polarity and phase, and the slave-select pattern all come from configuration inputs. Chip select works in one of two modes. In manual mode the select lines follow the written pattern at all times, so the device stays selected across a multi-word command. In automatic mode the pattern appears only while a word is shifting. A global enable can freeze a transfer part-way through and resume it later. A manual-start mode holds queued words until a start pulse arrives.

Top module: `sfm_engine`

## Requirements
- R1: The serial clock period is 2 << baud_i input clock cycles, for baud_i values 0 through 7 (a divider of 2 to 256).
- R2: On mosi_o the bytes of a word go out from the least significant byte upward, and each byte is sent most significant bit first.
- R3: A word pushed with tx_port_i = 0 sends 4 bytes, and one pushed with tx_port_i = 1, 2 or 3 sends that many bytes. A word of n bytes produces exactly 8·n sampling edges.
- R4: Each word pushes one receive entry. Its rx_nbytes_o equals the byte count that was sent. The first received byte sits in bits 7:0, the next bytes fill upward, and unused upper bytes read zero.
- R5: When no word is active, sck_o rests at cpol_i. With cpha_i = 0 the slave's bit is captured on the first clock edge of each bit; with cpha_i = 1 it is captured on the second edge.
- R6: While en_i is low, an active word is frozen: sck_o holds, busy_o stays high, and no shifting happens. No new word starts, and queued words stay in the transmit queue. Once en_i is set again, the word finishes with correct data.
- R7: With manual_cs_i high, ss_n_o always equals ss_sel_n_i. With manual_cs_i low, ss_n_o equals ss_sel_n_i only while busy_o is high, and is all ones otherwise. Select lines are active low.
- R8: With manual_start_i high, queued words wait until a start_i pulse. After the pulse, the engine sends every word that is queued. Once the queue runs empty, later words again wait for a new pulse.
- R9: Each queue holds 63 words. tx_full_o rises after the 63rd push, and a push while the queue is full is dropped.
- R10: After reset the engine is idle, both queues are empty, and tx_full_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: capture on first edge, 1: capture on second edge |
| baud_i | input | 3 | Divider code, period 2 << code |
| manual_cs_i | input | 1 | 1: select lines follow ss_sel_n_i at all times |
| manual_start_i | input | 1 | 1: words wait for a start pulse |
| start_i | input | 1 | Start pulse used in manual-start mode |
| ss_sel_n_i | input | SEL_W | Written select pattern, active low |
| tx_push_i | input | 1 | Push a word into the transmit queue |
| tx_port_i | input | 2 | Write port: 0 = 4 bytes, 1/2/3 = that many bytes |
| tx_word_i | input | 32 | Word to send |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_pop_i | input | 1 | Remove the head receive entry |
| rx_word_o | output | 32 | Head receive word |
| rx_nbytes_o | output | 3 | Valid byte count of the head receive word |
| rx_empty_o | output | 1 | Receive queue empty |
| busy_o | output | 1 | A word is in progress |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| ss_n_o | output | SEL_W | Slave select lines, active low |

## Verification
The assertions check on every cycle that the clock rests at its polarity level whenever the engine is idle, and that a cleared enable freezes the clock and holds off any new word. They also check the two select-line rules, that the transmit queue never reports full and empty together, and that every queued receive entry carries a count of one to four. Only the bench scenarios can show the data itself: the byte and bit order on the wire, correct sampling in all four clock modes, the measured divider periods, the partial-word receive packing, the hold-and-release behaviour of manual start, and dropped pushes at a depth of 63.

// File: rtl/sfm_pkg.sv
`timescale 1ns/1ps
package sfm_pkg;
    localparam int WORD_W = 32;
    localparam int NB_W   = 3;

    typedef logic [NB_W-1:0] nbytes_t;

    typedef struct packed {
        nbytes_t             nb;
        logic [WORD_W-1:0]   data;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } sh_state_e;

    typedef struct packed {
        sh_state_e          st;
        logic [7:0]         div;
        logic [5:0]         edge_n;
        nbytes_t            nb;
        logic [WORD_W-1:0]  txs;
        logic [WORD_W-1:0]  rxs;
        logic               sck;
        logic               armed;
    } sh_t;

    // Write port code to byte count: port 0 carries a full word.
    function automatic nbytes_t port_bytes(input logic [1:0] port);
        return (port == 2'd0) ? nbytes_t'(4) : nbytes_t'({1'b0, port});
    endfunction
endpackage

// File: rtl/sfm_fifo.sv
`timescale 1ns/1ps
module sfm_fifo #(
    parameter int W     = 35,
    parameter int DEPTH = 63
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t f_q, f_d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        f_d     = f_q;
        do_push = push_i && (f_q.cnt != CW'(DEPTH));
        do_pop  = pop_i  && (f_q.cnt != '0);
        if (do_push) f_d.wr = wrap_inc(f_q.wr);
        if (do_pop)  f_d.rd = wrap_inc(f_q.rd);
        if (do_push && !do_pop)      f_d.cnt = f_q.cnt + CW'(1);
        else if (!do_push && do_pop) f_d.cnt = f_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wr] <= wdata_i;
    end

    assign rdata_o = mem[f_q.rd];
    assign full_o  = (f_q.cnt == CW'(DEPTH));
    assign empty_o = (f_q.cnt == '0);
endmodule

// File: rtl/sfm_shifter.sv
`timescale 1ns/1ps
module sfm_shifter
    import sfm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic [2:0]       baud_i,
    input  logic             manual_start_i,
    input  logic             start_i,
    input  logic             tx_valid_i,
    input  logic [ENT_W-1:0] tx_ent_i,
    output logic             tx_pop_o,
    input  logic             rx_full_i,
    output logic             rx_push_o,
    output logic [ENT_W-1:0] rx_ent_o,
    output logic             sck_o,
    output logic             mosi_o,
    input  logic             miso_i,
    output logic             busy_o
);
    sh_t        s_q, s_d;
    ent_t       tx_ent, rx_ent;
    logic [7:0] half_m1;
    logic [5:0] last_edge;
    logic       tick, sample_now, shift_now, go;

    assign tx_ent = ent_t'(tx_ent_i);

    always_comb begin
        s_d       = s_q;
        tx_pop_o  = 1'b0;
        rx_push_o = 1'b0;
        half_m1   = (8'd1 << baud_i) - 8'd1;
        tick      = (s_q.div == half_m1);
        // 16 edges per byte; byte count 4 wraps to 0 in two bits
        last_edge = {s_q.nb[1:0] - 2'd1, 4'hF};
        sample_now = (s_q.edge_n[0] == cpha_i);
        shift_now  = cpha_i ? (!s_q.edge_n[0] && (s_q.edge_n != 6'd0))
                            : ( s_q.edge_n[0] && (s_q.edge_n != last_edge));
        go = en_i && tx_valid_i && !rx_full_i
             && (!manual_start_i || s_q.armed || start_i);

        unique case (s_q.st)
            ST_IDLE: begin
                s_d.sck   = cpol_i;
                s_d.div   = '0;
                s_d.armed = tx_valid_i ? (s_q.armed || start_i) : 1'b0;
                if (go) begin
                    tx_pop_o   = 1'b1;
                    s_d.st     = ST_SHIFT;
                    s_d.edge_n = '0;
                    s_d.nb     = tx_ent.nb;
                    s_d.rxs    = '0;
                    s_d.txs    = {tx_ent.data[7:0],   tx_ent.data[15:8],
                                  tx_ent.data[23:16], tx_ent.data[31:24]};
                end
            end
            ST_SHIFT: begin
                s_d.armed = s_q.armed || start_i;
                if (en_i) begin
                    if (tick) begin
                        s_d.div = '0;
                        s_d.sck = ~s_q.sck;
                        if (sample_now) s_d.rxs = {s_q.rxs[WORD_W-2:0], miso_i};
                        if (shift_now)  s_d.txs = {s_q.txs[WORD_W-2:0], 1'b0};
                        if (s_q.edge_n == last_edge) s_d.st = ST_TAIL;
                        else s_d.edge_n = s_q.edge_n + 6'd1;
                    end else begin
                        s_d.div = s_q.div + 8'd1;
                    end
                end
            end
            ST_TAIL: begin
                s_d.armed = s_q.armed || start_i;
                if (en_i) begin
                    if (tick) begin
                        rx_push_o = 1'b1;
                        s_d.st    = ST_IDLE;
                        s_d.div   = '0;
                    end else begin
                        s_d.div = s_q.div + 8'd1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    // Received bits arrive first byte first; place byte k at bits 8k+7:8k.
    always_comb begin
        rx_ent.nb   = s_q.nb;
        rx_ent.data = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(s_q.nb))
                rx_ent.data[8*k +: 8] = s_q.rxs[8*(int'(s_q.nb) - 1 - k) +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.st     <= ST_IDLE;
            s_q.nb     <= nbytes_t'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_ent_o = rx_ent;
    assign sck_o    = s_q.sck;
    assign mosi_o   = s_q.txs[WORD_W-1];
    assign busy_o   = (s_q.st != ST_IDLE);
endmodule

// File: rtl/sfm_engine.sv
`timescale 1ns/1ps
module sfm_engine
    import sfm_pkg::*;
#(
    parameter int DEPTH = 63,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic [2:0]        baud_i,
    input  logic              manual_cs_i,
    input  logic              manual_start_i,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  ss_sel_n_i,
    input  logic              tx_push_i,
    input  logic [1:0]        tx_port_i,
    input  logic [31:0]       tx_word_i,
    output logic              tx_full_o,
    output logic              tx_empty_o,
    input  logic              rx_pop_i,
    output logic [31:0]       rx_word_o,
    output logic [2:0]        rx_nbytes_o,
    output logic              rx_empty_o,
    output logic              busy_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [SEL_W-1:0]  ss_n_o
);
    ent_t             tx_in, tx_head, rx_in, rx_head;
    logic             tx_pop, rx_push, rx_full;
    logic [ENT_W-1:0] tx_head_bits, rx_in_bits, rx_head_bits;

    always_comb begin
        tx_in.nb   = port_bytes(tx_port_i);
        tx_in.data = tx_word_i;
    end

    sfm_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (tx_push_i),
        .wdata_i (tx_in),
        .pop_i   (tx_pop),
        .rdata_o (tx_head_bits),
        .full_o  (tx_full_o),
        .empty_o (tx_empty_o)
    );

    assign tx_head = ent_t'(tx_head_bits);

    sfm_shifter u_shift (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_i           (en_i),
        .cpol_i         (cpol_i),
        .cpha_i         (cpha_i),
        .baud_i         (baud_i),
        .manual_start_i (manual_start_i),
        .start_i        (start_i),
        .tx_valid_i     (!tx_empty_o),
        .tx_ent_i       (tx_head),
        .tx_pop_o       (tx_pop),
        .rx_full_i      (rx_full),
        .rx_push_o      (rx_push),
        .rx_ent_o       (rx_in_bits),
        .sck_o          (sck_o),
        .mosi_o         (mosi_o),
        .miso_i         (miso_i),
        .busy_o         (busy_o)
    );

    assign rx_in = ent_t'(rx_in_bits);

    sfm_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rx_push),
        .wdata_i (rx_in),
        .pop_i   (rx_pop_i),
        .rdata_o (rx_head_bits),
        .full_o  (rx_full),
        .empty_o (rx_empty_o)
    );

    assign rx_head     = ent_t'(rx_head_bits);
    assign rx_word_o   = rx_head.data;
    assign rx_nbytes_o = rx_head.nb;

    // Manual: lines follow the written pattern; automatic: only during a word.
    assign ss_n_o = (manual_cs_i || busy_o) ? ss_sel_n_i : '1;
endmodule

// File: rtl/sfm_engine_chk.sv
`timescale 1ns/1ps
module sfm_engine_chk #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             cpol_i,
    input logic             manual_cs_i,
    input logic [SEL_W-1:0] ss_sel_n_i,
    input logic             tx_full_o,
    input logic             tx_empty_o,
    input logic [2:0]       rx_nbytes_o,
    input logic             rx_empty_o,
    input logic             busy_o,
    input logic             sck_o,
    input logic [SEL_W-1:0] ss_n_o
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !busy_o && $past(!busy_o) && $stable(cpol_i)) |-> (sck_o == cpol_i));

    // R6
    en_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && busy_o) |=> ($stable(sck_o) && busy_o));

    // R6
    en_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !busy_o) |=> !busy_o);

    // R7
    ss_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        manual_cs_i |-> (ss_n_o == ss_sel_n_i));

    // R7
    ss_auto_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual_cs_i && !busy_o) |-> (ss_n_o == '1));

    // R9
    txq_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full_o && tx_empty_o));

    // R4
    rx_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_empty_o |-> (rx_nbytes_o != 3'd0 && rx_nbytes_o <= 3'd4));
endmodule

bind sfm_engine sfm_engine_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/sfm_engine_tb.sv
`timescale 1ns/1ps
module sfm_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en, cpol, cpha, manual_cs, manual_start, start;
    logic [2:0]  baud;
    logic [3:0]  ss_sel;
    logic        tx_push, rx_pop, flip;
    logic [1:0]  tx_port;
    logic [31:0] tx_word;
    logic        tx_full_o, tx_empty_o, rx_empty_o, busy_o, sck_o, mosi_o, miso;
    logic [31:0] rx_word_o;
    logic [2:0]  rx_nbytes_o;
    logic [3:0]  ss_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int mon_cnt  = 0;
    logic [31:0] mon_bits = '0;
    int last_rise = -1;
    int min_per   = 1000000;

    always #2 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;
    assign miso = mosi_o ^ flip;

    sfm_engine u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cpol_i(cpol), .cpha_i(cpha),
        .baud_i(baud), .manual_cs_i(manual_cs), .manual_start_i(manual_start),
        .start_i(start), .ss_sel_n_i(ss_sel), .tx_push_i(tx_push),
        .tx_port_i(tx_port), .tx_word_i(tx_word), .tx_full_o(tx_full_o),
        .tx_empty_o(tx_empty_o), .rx_pop_i(rx_pop), .rx_word_o(rx_word_o),
        .rx_nbytes_o(rx_nbytes_o), .rx_empty_o(rx_empty_o), .busy_o(busy_o),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso), .ss_n_o(ss_n_o)
    );

    // Independent wire monitor: records mosi at each capture edge.
    always @(sck_o) begin
        if (rst_n === 1'b1 && ss_n_o !== 4'hF) begin
            if ((sck_o !== cpol) == (cpha == 1'b0)) begin
                mon_bits = {mon_bits[30:0], mosi_o};
                mon_cnt++;
            end
            if (sck_o === 1'b1) begin
                if (last_rise >= 0 && (cyc - last_rise) < min_per) min_per = cyc - last_rise;
                last_rise = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bmask(input int n);
        return (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
    endfunction

    function automatic logic [31:0] stream_of(input logic [31:0] d, input int n);
        logic [31:0] r = '0;
        for (int k = 0; k < n; k++) r = (r << 8) | {24'h0, d[8*k +: 8]};
        return r;
    endfunction

    task automatic push(input logic [1:0] p, input logic [31:0] d);
        @(negedge clk);
        tx_push = 1'b1; tx_port = p; tx_word = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(tx_empty_o && !busy_o));
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_busy();
        do @(negedge clk); while (!busy_o);
    endtask

    task automatic pop_chk(input int n, input logic [31:0] d, input string req);
        @(negedge clk);
        chk(!rx_empty_o, req, "rx entry present", {63'h0, rx_empty_o}, 64'h0);
        chk(rx_nbytes_o == 3'(n), req, "rx byte count", 64'(rx_nbytes_o), 64'(n));
        chk(rx_word_o == d, req, "rx word", 64'(rx_word_o), 64'(d));
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic mon_reset();
        mon_cnt = 0; mon_bits = '0; last_rise = -1; min_per = 1000000;
    endtask

    // One word end to end: wire order (R2), edge count (R3), receive packing (R4).
    task automatic run_word(input logic [1:0] p, input logic [31:0] d, input logic fl);
        int n = (p == 2'd0) ? 4 : int'(p);
        logic [31:0] m = bmask(n);
        flip = fl;
        mon_reset();
        push(p, d);
        wait_idle();
        chk(mon_cnt == 8 * n, "R3", "capture edges", 64'(mon_cnt), 64'(8 * n));
        chk((mon_bits & m) == stream_of(d, n), "R2", "wire bit stream",
            64'(mon_bits & m), 64'(stream_of(d, n)));
        pop_chk(n, (d & m) ^ (fl ? m : 32'h0), "R4");
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy_o, "R10", "busy after reset", 64'(busy_o), 64'h0);
        chk(tx_empty_o && rx_empty_o, "R10", "queues empty", {62'h0, tx_empty_o, rx_empty_o}, 64'h3);
        chk(!tx_full_o, "R10", "tx full after reset", 64'(tx_full_o), 64'h0);
        chk(ss_n_o == 4'hF, "R7", "auto select idle", 64'(ss_n_o), 64'hF);
    endtask

    task automatic t_basic();
        cpol = 0; cpha = 0; baud = 3'd0;
        run_word(2'd0, 32'hA1B2_C3D4, 1'b0);
        chk(min_per == 2, "R1", "period at code 0", 64'(min_per), 64'd2);
    endtask

    task automatic t_partial();
        cpol = 1; cpha = 1; baud = 3'd1;
        run_word(2'd1, 32'h1122_3344, 1'b1);
        run_word(2'd2, 32'h5566_7788, 1'b1);
        run_word(2'd3, 32'h99AA_BBCC, 1'b0);
        chk(sck_o == 1'b1, "R5", "idle level with polarity 1", 64'(sck_o), 64'h1);
    endtask

    task automatic t_modes();
        cpol = 0; cpha = 1; baud = 3'd0;
        @(negedge clk);
        run_word(2'd0, 32'h5A0F_F0C3, 1'b1);
        chk(sck_o == 1'b0, "R5", "idle level with polarity 0", 64'(sck_o), 64'h0);
        cpol = 1; cpha = 0;
        @(negedge clk);
        run_word(2'd2, 32'h0000_BEEF, 1'b0);
    endtask

    task automatic t_div();
        cpol = 0; cpha = 0; baud = 3'd2;
        @(negedge clk);
        run_word(2'd1, 32'h0000_0096, 1'b0);
        chk(min_per == 8, "R1", "period at code 2", 64'(min_per), 64'd8);
        baud = 3'd7;
        run_word(2'd1, 32'h0000_003C, 1'b1);
        chk(min_per == 256, "R1", "period at code 7", 64'(min_per), 64'd256);
        baud = 3'd0;
    endtask

    task automatic t_enable();
        logic held;
        baud = 3'd1; flip = 0; mon_reset();
        en = 0;
        push(2'd0, 32'hCAFE_F00D);
        repeat (40) @(negedge clk);
        chk(!busy_o, "R6", "no start while disabled", 64'(busy_o), 64'h0);
        chk(!tx_empty_o, "R6", "word stays queued", 64'(tx_empty_o), 64'h0);
        en = 1;
        wait_busy();
        repeat (9) @(negedge clk);
        en = 0;
        @(negedge clk);
        held = sck_o;
        repeat (30) @(negedge clk);
        chk(sck_o == held && busy_o, "R6", "frozen mid word", {62'h0, sck_o, busy_o}, {62'h0, held, 1'b1});
        en = 1;
        wait_idle();
        chk(mon_cnt == 32, "R6", "edges after resume", 64'(mon_cnt), 64'd32);
        pop_chk(4, 32'hCAFE_F00D, "R6");
        baud = 3'd0;
    endtask

    task automatic t_cs();
        manual_cs = 1; ss_sel = 4'b1101; flip = 0;
        @(negedge clk);
        chk(ss_n_o == 4'b1101, "R7", "manual select while idle", 64'(ss_n_o), 64'hD);
        push(2'd1, 32'h0000_00A5);
        wait_busy();
        chk(ss_n_o == 4'b1101, "R7", "manual select during word", 64'(ss_n_o), 64'hD);
        wait_idle();
        chk(ss_n_o == 4'b1101, "R7", "manual select held after word", 64'(ss_n_o), 64'hD);
        pop_chk(1, 32'h0000_00A5, "R7");
        manual_cs = 0;
        @(negedge clk);
        chk(ss_n_o == 4'hF, "R7", "auto select idle", 64'(ss_n_o), 64'hF);
        push(2'd1, 32'h0000_005A);
        wait_busy();
        chk(ss_n_o == 4'b1101, "R7", "auto select during word", 64'(ss_n_o), 64'hD);
        wait_idle();
        pop_chk(1, 32'h0000_005A, "R7");
        ss_sel = 4'b1110;
    endtask

    task automatic t_manual();
        flip = 0; manual_start = 1;
        push(2'd0, 32'h0102_0304);
        push(2'd1, 32'h0000_0077);
        repeat (40) @(negedge clk);
        chk(!busy_o && !tx_empty_o, "R8", "held before start", {62'h0, busy_o, tx_empty_o}, 64'h0);
        start = 1; @(negedge clk); start = 0;
        wait_idle();
        pop_chk(4, 32'h0102_0304, "R8");
        pop_chk(1, 32'h0000_0077, "R8");
        push(2'd2, 32'h0000_1234);
        repeat (40) @(negedge clk);
        chk(!busy_o && !tx_empty_o, "R8", "held again after drain", {62'h0, busy_o, tx_empty_o}, 64'h0);
        manual_start = 0;
        wait_idle();
        pop_chk(2, 32'h0000_1234, "R8");
    endtask

    function automatic logic [31:0] depth_word(input int i);
        return {8'(i), 8'(~i), 8'(i + 3), 8'(i ^ 8'h55)};
    endfunction

    task automatic t_depth();
        int got = 0;
        flip = 0; en = 0;
        for (int i = 0; i < 63; i++) push(2'd0, depth_word(i));
        chk(tx_full_o, "R9", "full after 63 pushes", 64'(tx_full_o), 64'h1);
        push(2'd0, 32'hDEAD_BEEF);
        en = 1;
        wait_idle();
        while (!rx_empty_o && got < 70) begin
            if (rx_word_o != depth_word(got))
                chk(1'b0, "R9", "drained word", 64'(rx_word_o), 64'(depth_word(got)));
            rx_pop = 1; @(negedge clk); rx_pop = 0; @(negedge clk);
            got++;
        end
        chk(got == 63, "R9", "entries after overflow push", 64'(got), 64'd63);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_up();
    end

    initial begin
        en = 1; cpol = 0; cpha = 0; baud = 3'd0; manual_cs = 0; manual_start = 0;
        start = 0; ss_sel = 4'b1110; tx_push = 0; tx_port = 2'd0; tx_word = '0;
        rx_pop = 0; flip = 0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_basic();
        t_partial();
        t_modes();
        t_div();
        t_enable();
        t_cs();
        t_manual();
        t_depth();
        finish_up();
    end
endmodule